// File: doc/BRIEF.md
# Compressed Min-Sum Check Node

This block is a single check-node processor for a fully parallel min-sum decoder. Each variable connected to the check sends it one message in sign-magnitude form. The node also takes the syndrome bit measured for this check.

The node does not produce one reply per edge. It emits a compact summary instead, made of four fields:
- the overall sign parity,
- the position of the weakest incoming magnitude,
- that weakest magnitude,
- the next-weakest magnitude.

The variable side later rebuilds each per-edge reply from this summary. Because of that, the wires leaving the node stay narrow however large the degree is.

The magnitude reduction is a combinational tree of two-minimum merge cells. It is not pipelined. A single register stage follows it, so the summary for one set of messages appears one clock after those messages were sampled. The degree and the magnitude width are parameters.

Top module: `cn_compress_node`

## Requirements
- R1: Each message is MAG_W+1 bits wide. Message i sits at `msg_i[i*(MAG_W+1) +: MAG_W+1]`. Its most significant bit is the sign and its low MAG_W bits are the unsigned magnitude.
- R2: `min1_o` equals the smallest magnitude among the DEG incoming messages.
- R3: `sel_o` is the index of an input holding the smallest magnitude. When several inputs share that value, the lowest index is chosen. `sel_o` is always below DEG.
- R4: `min2_o` equals the second entry of the sorted magnitudes. It equals `min1_o` when the minimum occurs more than once. When DEG is 1 it is all ones.
- R5: `parity_o` is the XOR of all DEG sign bits and `syndrome_i`.
- R6: All outputs are registered. They reflect the inputs present at the preceding rising edge of `clk_i` and do not change between edges.
- R7: While `rst_ni` is low, all outputs are zero. The clear takes effect at once, without waiting for a clock edge.
- R8: Sign bits have no effect on `min1_o`, `min2_o` or `sel_o`.
- R9: `min1_o` never exceeds `min2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_i | input | DEG*(MAG_W+1) | Packed sign-magnitude messages, one per edge |
| syndrome_i | input | 1 | Measured syndrome bit for this check |
| parity_o | output | 1 | Sign parity folded with the syndrome |
| sel_o | output | SEL_W | Index of the smallest magnitude (SEL_W = ceil(log2(DEG)), at least 1) |
| min1_o | output | MAG_W | Smallest magnitude |
| min2_o | output | MAG_W | Second-smallest magnitude |

## Verification
A merge cell that resolves ties toward the higher half, or that drops the loser's minimum, shows up in the cycle after the stimulus. It appears as a wrong `sel_o` on patterns with repeated minima, or as a `min2_o` larger than the true runner-up. A fault in the leaf padding changes the results only for degrees that are not a power of two, and only when real inputs hold the all-ones value. The bench therefore mixes saturated magnitudes, narrow ranges that force ties, and sign-only changes, and it compares every field on every clock against a behavioural sort.

// File: rtl/cn_pkg.sv
package cn_pkg;
  function automatic int sel_width(int deg);
    return (deg > 1) ? $clog2(deg) : 1;
  endfunction
endpackage

// File: rtl/cn_msg_split.sv
module cn_msg_split #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5,
  localparam int MSG_W = MAG_W + 1
) (
  input  logic [DEG*MSG_W-1:0] msg_i,
  output logic [DEG-1:0]       sign_o,
  output logic [MAG_W-1:0]     mag_o [DEG]
);
  for (genvar i = 0; i < DEG; i++) begin : g_edge
    assign sign_o[i] = msg_i[i*MSG_W + MAG_W];
    assign mag_o[i]  = msg_i[i*MSG_W +: MAG_W];
  end
endmodule

// File: rtl/cn_min2_merge.sv
module cn_min2_merge #(
  parameter int MAG_W = 5,
  parameter int SEL_W = 3
) (
  input  logic [MAG_W-1:0] lo_min1_i,
  input  logic [MAG_W-1:0] lo_min2_i,
  input  logic [SEL_W-1:0] lo_sel_i,
  input  logic [MAG_W-1:0] hi_min1_i,
  input  logic [MAG_W-1:0] hi_min2_i,
  input  logic [SEL_W-1:0] hi_sel_i,
  output logic [MAG_W-1:0] min1_o,
  output logic [MAG_W-1:0] min2_o,
  output logic [SEL_W-1:0] sel_o
);
  // lower-index side wins ties
  always_comb begin
    if (hi_min1_i < lo_min1_i) begin
      min1_o = hi_min1_i;
      sel_o  = hi_sel_i;
      min2_o = (lo_min1_i < hi_min2_i) ? lo_min1_i : hi_min2_i;
    end else begin
      min1_o = lo_min1_i;
      sel_o  = lo_sel_i;
      min2_o = (hi_min1_i < lo_min2_i) ? hi_min1_i : lo_min2_i;
    end
  end
endmodule

// File: rtl/cn_min2_tree.sv
module cn_min2_tree #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5,
  parameter int SEL_W = cn_pkg::sel_width(DEG)
) (
  input  logic [MAG_W-1:0] mag_i [DEG],
  output logic [MAG_W-1:0] min1_o,
  output logic [MAG_W-1:0] min2_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int LEAVES = 1 << SEL_W;

  for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
    localparam int W = LEAVES >> l;
    logic [MAG_W-1:0] m1 [W];
    logic [MAG_W-1:0] m2 [W];
    logic [SEL_W-1:0] ix [W];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_in
        if (i < DEG) begin : g_real
          assign m1[i] = mag_i[i];
        end else begin : g_pad
          assign m1[i] = '1;  // padding never beats a real input on a tie
        end
        assign m2[i] = '1;
        assign ix[i] = SEL_W'(i);
      end
    end else begin : g_merge
      for (genvar k = 0; k < W; k++) begin : g_node
        cn_min2_merge #(.MAG_W(MAG_W), .SEL_W(SEL_W)) u_merge (
          .lo_min1_i (g_lvl[l-1].m1[2*k]),
          .lo_min2_i (g_lvl[l-1].m2[2*k]),
          .lo_sel_i  (g_lvl[l-1].ix[2*k]),
          .hi_min1_i (g_lvl[l-1].m1[2*k+1]),
          .hi_min2_i (g_lvl[l-1].m2[2*k+1]),
          .hi_sel_i  (g_lvl[l-1].ix[2*k+1]),
          .min1_o    (m1[k]),
          .min2_o    (m2[k]),
          .sel_o     (ix[k])
        );
      end
    end
  end

  assign min1_o = g_lvl[SEL_W].m1[0];
  assign min2_o = g_lvl[SEL_W].m2[0];
  assign sel_o  = g_lvl[SEL_W].ix[0];
endmodule

// File: rtl/cn_compress_node.sv
module cn_compress_node #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5,
  localparam int MSG_W = MAG_W + 1,
  localparam int SEL_W = cn_pkg::sel_width(DEG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEG*MSG_W-1:0] msg_i,
  input  logic                 syndrome_i,
  output logic                 parity_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic [MAG_W-1:0]     min1_o,
  output logic [MAG_W-1:0]     min2_o
);
  logic [DEG-1:0]   sign;
  logic [MAG_W-1:0] mag [DEG];
  logic [MAG_W-1:0] min1_d, min2_d;
  logic [SEL_W-1:0] sel_d;
  logic             parity_d;
  logic             primed_q;

  cn_msg_split #(.DEG(DEG), .MAG_W(MAG_W)) u_split (
    .msg_i  (msg_i),
    .sign_o (sign),
    .mag_o  (mag)
  );

  cn_min2_tree #(.DEG(DEG), .MAG_W(MAG_W), .SEL_W(SEL_W)) u_tree (
    .mag_i  (mag),
    .min1_o (min1_d),
    .min2_o (min2_d),
    .sel_o  (sel_d)
  );

  assign parity_d = ^{sign, syndrome_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parity_o <= 1'b0;
      sel_o    <= '0;
      min1_o   <= '0;
      min2_o   <= '0;
      primed_q <= 1'b0;
    end else begin
      parity_o <= parity_d;
      sel_o    <= sel_d;
      min1_o   <= min1_d;
      min2_o   <= min2_d;
      primed_q <= 1'b1;
    end
  end

  p_min_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min1_o <= min2_o);

  p_sel_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (int'(sel_o) < DEG));

  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (parity_o == ($past(^sign) ^ $past(syndrome_i))));

  for (genvar j = 0; j < DEG; j++) begin : g_chk
    p_min1_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> (min1_o <= $past(mag[j])));
    p_min1_at_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && sel_o == SEL_W'(j)) |-> (min1_o == $past(mag[j])));
    p_tie_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && SEL_W'(j) < sel_o) |-> ($past(mag[j]) > min1_o));
  end
endmodule

// File: tb/cn_compress_node_tb.sv
module cn_compress_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEG   = 6;
  localparam int MAG_W = 5;
  localparam int MSG_W = MAG_W + 1;
  localparam int SEL_W = 3;
  localparam int MAXV  = (1 << MAG_W) - 1;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [DEG*MSG_W-1:0] msg = '0;
  logic                 syn = 1'b0;
  logic                 parity_o;
  logic [SEL_W-1:0]     sel_o;
  logic [MAG_W-1:0]     min1_o, min2_o;

  int n_checks = 0;
  int n_err    = 0;
  int e_min1 = 0, e_min2 = 0, e_sel = 0, e_par = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cn_compress_node #(.DEG(DEG), .MAG_W(MAG_W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .msg_i      (msg),
    .syndrome_i (syn),
    .parity_o   (parity_o),
    .sel_o      (sel_o),
    .min1_o     (min1_o),
    .min2_o     (min2_o)
  );

  task automatic check(string req, string fld, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, fld, act, exp);
    end
  endtask

  // R1 layout: sign on top bit, magnitude below
  function automatic logic [DEG*MSG_W-1:0] mk(int mg [DEG], logic [DEG-1:0] sg);
    logic [DEG*MSG_W-1:0] v = '0;
    for (int i = 0; i < DEG; i++) v[i*MSG_W +: MSG_W] = {sg[i], MAG_W'(mg[i])};
    return v;
  endfunction

  // behavioural sort model
  task automatic model(logic [DEG*MSG_W-1:0] m, logic s);
    int a = MAXV + 1, b = MAXV + 1, ix = 0, p = s;
    for (int i = 0; i < DEG; i++) begin
      int v = int'(m[i*MSG_W +: MAG_W]);
      p ^= m[i*MSG_W + MAG_W];
      if (v < a) begin b = a; a = v; ix = i; end
      else if (v < b) b = v;
    end
    if (b > MAXV) b = MAXV;
    e_min1 = a; e_min2 = b; e_sel = ix; e_par = p;
  endtask

  task automatic apply(logic [DEG*MSG_W-1:0] m, logic s);
    msg = m; syn = s;
    #(CLK_PERIOD/4);
    check("R6", "min1 held before edge", int'(min1_o), e_min1);
    check("R6", "parity held before edge", int'(parity_o), e_par);
    model(m, s);
    @(posedge clk); @(negedge clk);
    check("R2", "min1", int'(min1_o), e_min1);
    check("R3", "sel", int'(sel_o), e_sel);
    check("R4", "min2", int'(min2_o), e_min2);
    check("R5", "parity", int'(parity_o), e_par);
    check("R9", "min1<=min2", int'(min1_o <= min2_o), 1);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    n_err++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [DEG*MSG_W-1:0] v;
    int s1, s2, sx;
    msg = mk('{7, 3, 9, 1, 4, 2}, 6'b101101);
    syn = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7", "min1 in reset", int'(min1_o), 0);
    check("R7", "min2 in reset", int'(min2_o), 0);
    check("R7", "sel in reset", int'(sel_o), 0);
    check("R7", "parity in reset", int'(parity_o), 0);
    rst_ni = 1'b1;

    apply(mk('{1, 2, 3, 4, 5, 6}, 6'b000000), 1'b0);
    apply(mk('{6, 5, 4, 3, 2, 1}, 6'b000001), 1'b0);
    apply(mk('{9, 9, 9, 9, 9, 9}, 6'b111111), 1'b1);      // R3 R4 all equal
    apply(mk('{20, 15, 3, 8, 3, 30}, 6'b010010), 1'b0);   // R3 tie at 2 and 4
    apply(mk('{MAXV, MAXV, MAXV, MAXV, MAXV, MAXV}, 6'b100000), 1'b1);
    apply(mk('{0, 0, 0, 0, 0, 0}, 6'b000000), 1'b1);
    apply(mk('{MAXV, MAXV, MAXV, MAXV, MAXV, 0}, 6'b011000), 1'b0);
    apply(mk('{5, MAXV, MAXV, MAXV, MAXV, MAXV}, 6'b000000), 1'b0);

    // R8: same magnitudes, flipped signs
    v = mk('{12, 7, 19, 7, 2, 25}, 6'b001100);
    apply(v, 1'b0);
    s1 = int'(min1_o); s2 = int'(min2_o); sx = int'(sel_o);
    apply(mk('{12, 7, 19, 7, 2, 25}, 6'b110011), 1'b0);
    check("R8", "min1 sign-invariant", int'(min1_o), s1);
    check("R8", "min2 sign-invariant", int'(min2_o), s2);
    check("R8", "sel sign-invariant", int'(sel_o), sx);

    // R7: asynchronous clear mid-run
    rst_ni = 1'b0;
    #1;
    check("R7", "min1 async clear", int'(min1_o), 0);
    check("R7", "min2 async clear", int'(min2_o), 0);
    check("R7", "sel async clear", int'(sel_o), 0);
    check("R7", "parity async clear", int'(parity_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    e_min1 = 0; e_min2 = 0; e_sel = 0; e_par = 0;

    for (int n = 0; n < 300; n++) begin
      int mg [DEG];
      int hi = (n % 3 == 0) ? 3 : MAXV;
      for (int i = 0; i < DEG; i++) mg[i] = $urandom_range(0, hi);
      apply(mk(mg, DEG'($urandom)), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule